// File: doc/BRIEF.md
# Time-Multiplexed Multiport Read RAM

This block lets several pixel-fetch engines share one true dual-port block RAM. The RAM core runs at a multiple of the pixel rate. A free-running phase counter splits each pixel period into PHASES core cycles. Every read port owns one phase slot, and in that slot the RAM's first port serves it alone. The second RAM port belongs to the host on every cycle, for both reads and writes. Host traffic therefore never takes time away from the pixel ports.

Each read port returns 16-bit data together with an echoed copy of the address that produced it. The echo travels through the same number of register stages as the data, so downstream raster logic can pair every word with its address without any extra bookkeeping. With a 125 MHz core and five phases, each of the five read ports receives one word per 25 MHz pixel period. The phase value is brought out so that pixel-rate logic can advance on phase zero.

Top module: `mpr_multiport_ram`

## Requirements
- R1: `phase_o` is 0 in the first cycle after reset, rises by one each clock and wraps from PHASES-1 back to 0.
- R2: While reset is active, and for the two clocks it takes to release internally, `phase_o`, every `rd_addr_o` slice and every `rd_data_o` slice read zero.
- R3: Read port k (slice k of `rd_addr_i`, bits k*ADDR_W upward) samples its address at the clock edge that ends a cycle with phase k. Two edges later, slice k of `rd_addr_o` shows that address.
- R4: Slice k of `rd_data_o` is updated at the same edge as the echo in R3. It holds the memory word at the echoed address as it stood just before the edge one cycle after sampling.
- R5: Between its updates, which come once every PHASES cycles, each port's data and echoed address stay unchanged.
- R6: Suppose the host writes an address in the same cycle that a read port's access reads it. That read returns the old word, and only later reads return the new word.
- R7: `host_rdata_o` holds, one edge after the request, the word stored at `host_addr_i` just before that edge. When `host_we_i` is high, the edge writes `host_wdata_i` to that address.
- R8: Host writes, on any cycle and to any address, never delay or reorder pixel reads. The slot timing of R3 and R4 holds under continuous host writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, a multiple of the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_addr_i | input | NUM_RD*ADDR_W | Packed read addresses, port k at bits k*ADDR_W upward |
| rd_addr_o | output | NUM_RD*ADDR_W | Echoed addresses aligned with the read data |
| rd_data_o | output | NUM_RD*DATA_W | Read data per port, held between slots |
| phase_o | output | PHASE_W | Current phase; pixel-rate logic advances on zero |
| host_addr_i | input | ADDR_W | Host address |
| host_we_i | input | 1 | Host write enable |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Host read data, one cycle after the address |

## Verification
The bench builds the block with five read ports and five phases, which matches the stated 125/25 MHz ratio. In that configuration every phase is a live slot and two ports' update edges fall across the wrap back to phase zero. ADDR_W is cut to 8, so the host can preload the whole 256-word array in a few hundred cycles, and both address extremes are easy to reach. A directed stretch has the host rewrite the address that all five ports are reading on every cycle. This exposes the read-before-write ordering in every slot.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

  // Clock edges from a port's address sample to its output update.
  localparam int unsigned RD_PIPE_DEPTH = 2;

  // Phase value of the cycle whose closing edge updates port 'port'.
  function automatic int unsigned upd_phase(int unsigned port, int unsigned phases);
    return (port + RD_PIPE_DEPTH) % phases;
  endfunction

  // Select width that stays legal for a single port.
  function automatic int unsigned sel_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mpr_phase_gen.sv
module mpr_phase_gen #(
  parameter int unsigned PHASES  = 5,
  parameter int unsigned PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [PHASE_W-1:0] phase_o
);

  localparam logic [PHASE_W-1:0] LAST_PH = PHASE_W'(PHASES - 1);

  logic [PHASE_W-1:0] ph_q;
  logic [PHASE_W-1:0] ph_d;

  always_comb begin
    if (ph_q == LAST_PH) ph_d = '0;
    else                 ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign phase_o = ph_q;

endmodule

// File: rtl/mpr_slot_sched.sv
module mpr_slot_sched #(
  parameter int unsigned NUM_RD  = 5,
  parameter int unsigned PHASE_W = 4,
  parameter int unsigned SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] phase_i,
  output logic [NUM_RD-1:0]  sample_en_o,
  output logic               issue_v_o,
  output logic [SEL_W-1:0]   issue_sel_o,
  output logic [NUM_RD-1:0]  upd_en_o
);

  localparam logic [PHASE_W:0] NRD_L = (PHASE_W + 1)'(NUM_RD);

  logic             issue_v_q,  issue_v_d;
  logic [SEL_W-1:0] issue_sel_q, issue_sel_d;
  logic             ret_v_q,    ret_v_d;
  logic [SEL_W-1:0] ret_sel_q,  ret_sel_d;

  // Slot k is live in phase k; phases past the last port are idle.
  always_comb begin
    issue_v_d   = ({1'b0, phase_i} < NRD_L);
    issue_sel_d = issue_v_d ? SEL_W'(phase_i) : '0;
    ret_v_d     = issue_v_q;
    ret_sel_d   = issue_sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_v_q   <= 1'b0;
      issue_sel_q <= '0;
      ret_v_q     <= 1'b0;
      ret_sel_q   <= '0;
    end else begin
      issue_v_q   <= issue_v_d;
      issue_sel_q <= issue_sel_d;
      ret_v_q     <= ret_v_d;
      ret_sel_q   <= ret_sel_d;
    end
  end

  for (genvar k = 0; k < NUM_RD; k++) begin : g_dec
    assign sample_en_o[k] = (phase_i == PHASE_W'(k));
    assign upd_en_o[k]    = ret_v_q && (ret_sel_q == SEL_W'(k));
  end

  assign issue_v_o   = issue_v_q;
  assign issue_sel_o = issue_sel_q;

endmodule

// File: rtl/mpr_port_lane.sv
module mpr_port_lane #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en_i,
  input  logic              upd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] ram_q_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  logic [ADDR_W-1:0] req_q,  req_d;
  logic [ADDR_W-1:0] echo_q, echo_d;
  logic [DATA_W-1:0] hold_q, hold_d;

  // Stage 1: request latch; stage 2: echo and data registers together.
  always_comb begin
    req_d  = sample_en_i ? addr_i  : req_q;
    echo_d = upd_en_i    ? req_q   : echo_q;
    hold_d = upd_en_i    ? ram_q_i : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      echo_q <= '0;
      hold_q <= '0;
    end else begin
      req_q  <= req_d;
      echo_q <= echo_d;
      hold_q <= hold_d;
    end
  end

  assign req_addr_o = req_q;
  assign addr_o     = echo_q;
  assign data_o     = hold_q;

endmodule

// File: rtl/mpr_dp_ram.sv
module mpr_dp_ram #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              a_en_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  output logic [DATA_W-1:0] a_q_o,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic              b_we_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_q_o
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] a_q;
  logic [DATA_W-1:0] b_q;

  // Both reads see the array before this edge's write: read-first.
  always_ff @(posedge clk) begin
    if (a_en_i) a_q <= mem_q[a_addr_i];
    b_q <= mem_q[b_addr_i];
    if (b_we_i) mem_q[b_addr_i] <= b_wdata_i;
  end

  assign a_q_o = a_q;
  assign b_q_o = b_q;

endmodule

// File: rtl/mpr_multiport_ram.sv
module mpr_multiport_ram #(
  parameter int unsigned NUM_RD  = 5,
  parameter int unsigned PHASES  = 5,
  parameter int unsigned PHASE_W = 4,
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned DATA_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_RD*ADDR_W-1:0]   rd_addr_i,
  output logic [NUM_RD*ADDR_W-1:0]   rd_addr_o,
  output logic [NUM_RD*DATA_W-1:0]   rd_data_o,
  output logic [PHASE_W-1:0]         phase_o,
  input  logic [ADDR_W-1:0]          host_addr_i,
  input  logic                       host_we_i,
  input  logic [DATA_W-1:0]          host_wdata_i,
  output logic [DATA_W-1:0]          host_rdata_o
);

  localparam int unsigned SEL_W = mpr_pkg::sel_width(NUM_RD);

  // Reset: asserted at once, released after two clean edges.
  logic [1:0] rst_sync_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  logic [PHASE_W-1:0] phase;
  logic [NUM_RD-1:0]  sample_en;
  logic [NUM_RD-1:0]  upd_en;
  logic               issue_v;
  logic [SEL_W-1:0]   issue_sel;
  logic [ADDR_W-1:0]  req_addr [NUM_RD];
  logic [ADDR_W-1:0]  ram_a_addr;
  logic [DATA_W-1:0]  ram_a_q;

  mpr_phase_gen #(
    .PHASES  (PHASES),
    .PHASE_W (PHASE_W)
  ) u_phase (
    .clk     (clk),
    .rst_n   (rst_q),
    .phase_o (phase)
  );

  mpr_slot_sched #(
    .NUM_RD  (NUM_RD),
    .PHASE_W (PHASE_W),
    .SEL_W   (SEL_W)
  ) u_sched (
    .clk         (clk),
    .rst_n       (rst_q),
    .phase_i     (phase),
    .sample_en_o (sample_en),
    .issue_v_o   (issue_v),
    .issue_sel_o (issue_sel),
    .upd_en_o    (upd_en)
  );

  for (genvar k = 0; k < NUM_RD; k++) begin : g_lane
    mpr_port_lane #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
    ) u_lane (
      .clk         (clk),
      .rst_n       (rst_q),
      .sample_en_i (sample_en[k]),
      .upd_en_i    (upd_en[k]),
      .addr_i      (rd_addr_i[k*ADDR_W +: ADDR_W]),
      .ram_q_i     (ram_a_q),
      .req_addr_o  (req_addr[k]),
      .addr_o      (rd_addr_o[k*ADDR_W +: ADDR_W]),
      .data_o      (rd_data_o[k*DATA_W +: DATA_W])
    );
  end

  // Address mux onto the shared RAM port, steered by the issuing slot.
  always_comb begin
    ram_a_addr = '0;
    for (int k = 0; k < NUM_RD; k++) begin
      if (issue_sel == SEL_W'(k)) ram_a_addr = req_addr[k];
    end
  end

  mpr_dp_ram #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ram (
    .clk       (clk),
    .a_en_i    (issue_v),
    .a_addr_i  (ram_a_addr),
    .a_q_o     (ram_a_q),
    .b_addr_i  (host_addr_i),
    .b_we_i    (host_we_i),
    .b_wdata_i (host_wdata_i),
    .b_q_o     (host_rdata_o)
  );

  assign phase_o = phase;

endmodule

// File: rtl/mpr_multiport_ram_chk.sv
module mpr_multiport_ram_chk #(
  parameter int unsigned NUM_RD  = 5,
  parameter int unsigned PHASES  = 5,
  parameter int unsigned PHASE_W = 4,
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned DATA_W  = 16
) (
  input logic                     clk,
  input logic                     rst_q,
  input logic [PHASE_W-1:0]       phase_o,
  input logic [NUM_RD*ADDR_W-1:0] rd_addr_i,
  input logic [NUM_RD*ADDR_W-1:0] rd_addr_o,
  input logic [NUM_RD*DATA_W-1:0] rd_data_o,
  input logic [ADDR_W-1:0]        host_addr_i,
  input logic                     host_we_i,
  input logic [DATA_W-1:0]        host_wdata_i,
  input logic [DATA_W-1:0]        host_rdata_o
);

  localparam logic [PHASE_W-1:0] LAST_PH  = PHASE_W'(PHASES - 1);
  localparam int unsigned        LIVE_W   = $clog2(NUM_RD + 3) + 1;
  localparam logic [LIVE_W-1:0]  LIVE_CAP = LIVE_W'(NUM_RD + 2);

  // Cycles since internal reset release, saturating.
  logic [LIVE_W-1:0] live_q;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)                 live_q <= '0;
    else if (live_q != LIVE_CAP) live_q <= live_q + 1'b1;
  end

  // R1
  a_r1_phase_wrap: assert property (@(posedge clk) disable iff (!rst_q)
    (phase_o == LAST_PH) |=> (phase_o == '0));

  // R1
  a_r1_phase_step: assert property (@(posedge clk) disable iff (!rst_q)
    (phase_o != LAST_PH) |=> (phase_o == $past(phase_o) + 1'b1));

  // R7
  a_r7_write_then_read: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(host_we_i) && (host_addr_i == $past(host_addr_i)))
      |=> (host_rdata_o == $past(host_wdata_i, 2)));

  for (genvar k = 0; k < NUM_RD; k++) begin : g_port
    localparam logic [PHASE_W-1:0] UPD_PH   = PHASE_W'(mpr_pkg::upd_phase(k, PHASES));
    localparam logic [LIVE_W-1:0]  MIN_LIVE = LIVE_W'(k + 2);

    // R3
    a_r3_addr_echo: assert property (@(posedge clk) disable iff (!rst_q)
      ((phase_o == UPD_PH) && (live_q >= MIN_LIVE))
        |=> (rd_addr_o[k*ADDR_W +: ADDR_W] == $past(rd_addr_i[k*ADDR_W +: ADDR_W], 3)));

    // R5
    a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_q)
      (phase_o != UPD_PH) |=> $stable(rd_data_o[k*DATA_W +: DATA_W]));

    // R5
    a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_q)
      (phase_o != UPD_PH) |=> $stable(rd_addr_o[k*ADDR_W +: ADDR_W]));
  end

endmodule

bind mpr_multiport_ram mpr_multiport_ram_chk #(
  .NUM_RD  (NUM_RD),
  .PHASES  (PHASES),
  .PHASE_W (PHASE_W),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk          (clk),
  .rst_q        (rst_q),
  .phase_o      (phase_o),
  .rd_addr_i    (rd_addr_i),
  .rd_addr_o    (rd_addr_o),
  .rd_data_o    (rd_data_o),
  .host_addr_i  (host_addr_i),
  .host_we_i    (host_we_i),
  .host_wdata_i (host_wdata_i),
  .host_rdata_o (host_rdata_o)
);

// File: tb/test_mpr_multiport_ram.sv
module test_mpr_multiport_ram;

  localparam int NUM_RD  = 5;
  localparam int PHASES  = 5;
  localparam int PHASE_W = 4;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;
  localparam int DEPTH   = 1 << ADDR_W;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                     rst_n;
  logic [NUM_RD*ADDR_W-1:0] rd_addr_i;
  logic [NUM_RD*ADDR_W-1:0] rd_addr_o;
  logic [NUM_RD*DATA_W-1:0] rd_data_o;
  logic [PHASE_W-1:0]       phase_o;
  logic [ADDR_W-1:0]        host_addr_i;
  logic                     host_we_i;
  logic [DATA_W-1:0]        host_wdata_i;
  logic [DATA_W-1:0]        host_rdata_o;

  logic [ADDR_W-1:0] drv_addr [NUM_RD];

  always_comb begin
    for (int k = 0; k < NUM_RD; k++) rd_addr_i[k*ADDR_W +: ADDR_W] = drv_addr[k];
  end

  mpr_multiport_ram #(
    .NUM_RD  (NUM_RD),
    .PHASES  (PHASES),
    .PHASE_W (PHASE_W),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) i_mpr_multiport_ram (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_addr_i    (rd_addr_i),
    .rd_addr_o    (rd_addr_o),
    .rd_data_o    (rd_data_o),
    .phase_o      (phase_o),
    .host_addr_i  (host_addr_i),
    .host_we_i    (host_we_i),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Behavioural reference: pending read list plus a word array.
  typedef struct {
    int                port;
    int                addr;
    logic [DATA_W-1:0] data;
    bit                read_done;
  } pend_t;

  pend_t             pend [$];
  logic [DATA_W-1:0] mem_m [DEPTH];
  int                ph_m;
  int                sync_m;
  bit                in_rst_m;
  logic [ADDR_W-1:0] exp_addr [NUM_RD];
  logic [DATA_W-1:0] exp_data [NUM_RD];
  bit                upd_m    [NUM_RD];
  logic [DATA_W-1:0] exp_host;
  string             data_tag = "R4";

  task automatic reset_model();
    ph_m = 0;
    pend.delete();
    for (int k = 0; k < NUM_RD; k++) begin
      exp_addr[k] = '0;
      exp_data[k] = '0;
    end
  endtask

  // Advance the model over the coming rising edge, using the driven inputs.
  task automatic model_edge();
    logic [DATA_W-1:0] hrd;
    pend_t             keep [$];
    hrd = mem_m[host_addr_i];
    for (int k = 0; k < NUM_RD; k++) upd_m[k] = 0;
    if (!rst_n) begin
      sync_m   = 0;
      in_rst_m = 1;
      reset_model();
    end else if (sync_m < 2) begin
      sync_m++;
      in_rst_m = 1;
    end else begin
      in_rst_m = 0;
      foreach (pend[i]) begin
        pend_t e;
        e = pend[i];
        if (!e.read_done) begin
          e.data      = mem_m[e.addr];
          e.read_done = 1;
          keep.push_back(e);
        end else begin
          exp_addr[e.port] = ADDR_W'(e.addr);
          exp_data[e.port] = e.data;
          upd_m[e.port]    = 1;
        end
      end
      pend = keep;
      if (ph_m < NUM_RD) begin
        pend_t n;
        n.port      = ph_m;
        n.addr      = int'(drv_addr[ph_m]);
        n.data      = 'x;
        n.read_done = 0;
        pend.push_back(n);
      end
      ph_m = (ph_m + 1) % PHASES;
    end
    exp_host = hrd;
    if (host_we_i) mem_m[host_addr_i] = host_wdata_i;
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    string ta, td;
    chk(in_rst_m ? "R2" : "R1", "phase", 32'(phase_o), 32'(ph_m));
    for (int k = 0; k < NUM_RD; k++) begin
      ta = in_rst_m ? "R2" : (upd_m[k] ? "R3" : "R5");
      td = in_rst_m ? "R2" : (upd_m[k] ? data_tag : "R5");
      chk(ta, $sformatf("addr echo port %0d", k),
          32'(rd_addr_o[k*ADDR_W +: ADDR_W]), 32'(exp_addr[k]));
      if (!$isunknown(exp_data[k]))
        chk(td, $sformatf("data port %0d", k),
            32'(rd_data_o[k*DATA_W +: DATA_W]), 32'(exp_data[k]));
    end
    if (!$isunknown(exp_host))
      chk("R7", "host read", 32'(host_rdata_o), 32'(exp_host));
  endtask

  task automatic tick();
    model_edge();
    @(negedge clk);
    compare();
  endtask

  function automatic logic [DATA_W-1:0] pattern(int a);
    return DATA_W'((a * 37 + 16'h1234) ^ (a << 8));
  endfunction

  initial begin
    rst_n        = 1'b0;
    host_addr_i  = '0;
    host_we_i    = 1'b0;
    host_wdata_i = '0;
    for (int k = 0; k < NUM_RD; k++) drv_addr[k] = '0;
    for (int a = 0; a < DEPTH; a++) mem_m[a] = 'x;
    sync_m   = 0;
    in_rst_m = 1;
    exp_host = 'x;
    reset_model();
    @(negedge clk);

    // R2: reset state held while reset is low.
    for (int i = 0; i < 4; i++) tick();
    rst_n = 1'b1;

    // Preload through the host port while ports walk the array (R4, R7).
    for (int a = 0; a < DEPTH; a++) begin
      host_we_i    = 1'b1;
      host_addr_i  = ADDR_W'(a);
      host_wdata_i = pattern(a);
      for (int k = 0; k < NUM_RD; k++) drv_addr[k] = ADDR_W'(a + 40 * k);
      tick();
    end
    host_we_i = 1'b0;

    // R4: random reads, host reading random words (R7).
    for (int i = 0; i < 300; i++) begin
      host_addr_i = ADDR_W'($urandom);
      for (int k = 0; k < NUM_RD; k++) drv_addr[k] = ADDR_W'($urandom);
      tick();
    end

    // R4: address extremes, all ports on the same address.
    for (int i = 0; i < 40; i++) begin
      for (int k = 0; k < NUM_RD; k++)
        drv_addr[k] = (i % 2 == 0) ? ADDR_W'(0) : ADDR_W'(DEPTH - 1);
      tick();
    end

    // R6: host rewrites the word all ports read, on every cycle.
    data_tag = "R6";
    for (int i = 0; i < 60; i++) begin
      for (int k = 0; k < NUM_RD; k++) drv_addr[k] = ADDR_W'(7);
      host_we_i    = 1'b1;
      host_addr_i  = ADDR_W'(7);
      host_wdata_i = DATA_W'(16'hA000 + i);
      tick();
    end

    // R8: continuous random host writes against random reads.
    data_tag = "R8";
    for (int i = 0; i < 300; i++) begin
      host_we_i    = 1'b1;
      host_addr_i  = ADDR_W'($urandom);
      host_wdata_i = DATA_W'($urandom);
      for (int k = 0; k < NUM_RD; k++) drv_addr[k] = ADDR_W'($urandom);
      tick();
    end
    host_we_i = 1'b0;

    // R2: reset in mid-run, then resume reading (R4).
    data_tag = "R4";
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) tick();
    rst_n = 1'b1;
    for (int i = 0; i < 40; i++) begin
      for (int k = 0; k < NUM_RD; k++) drv_addr[k] = ADDR_W'(DEPTH - 1 - 3 * i - k);
      tick();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule